// File: doc/BRIEF.md
# Transmitter Mode Sequencer

This block takes a requested operating mode for a transmitter front end and walks the front end up or down to it one mode at a time. The four modes rank upward: sleep, standby, synthesizer, transmit. Each mode switches on one more subsystem. Standby turns on the crystal oscillator. Synthesizer mode adds the frequency synthesizer. Transmit mode adds the power amplifier. The sequencer passes through every intermediate mode on its own. It moves upward only when the matching handshake input shows that the lower stage is ready: the crystal-ready input, then the PLL-lock input. After that it also waits for the amplifier set-up delay.

The set-up delay is counted in clock cycles, with `CYC_PER_US` cycles per microsecond. For frequency-shift keying the delay comes from a 4-bit ramp code. For on-off keying the delay is 5 us plus half a bit period, and the bit period is given in clock cycles. A request for a lower mode needs no handshake. The enables drop one mode per clock, highest stage first. Losing lock while transmitting sends the block back to synthesizer mode, where it waits for lock again.

All control and status pins are plain levels. No data stream passes through the block, so it has no valid/ready interface.

Top module: `txmode_seq`

## Requirements
- R1: After reset, `mode` is 000 and `xo_en`, `fs_en`, `pa_en`, `locked` and `tx_ready` are low. `rc_en` is `rc_on_req` registered one clock late, in every mode.
- R2: `mode` uses the codes 000 sleep, 001 standby, 010 synthesizer and 011 transmit. `xo_en` is high in modes 001 and above, `fs_en` in modes 010 and above, and `pa_en` in mode 011 only.
- R3: `req_mode` codes 100 to 111 are ignored. The previously accepted target and the current mode are held.
- R4: `req_mode` is registered as the target one clock after it is presented. When the mode is sleep and the target is higher, the mode becomes standby on the next clock without any handshake.
- R5: When the mode is standby and the target is higher, the mode advances to synthesizer only on a clock where `xtal_rdy` is high.
- R6: When the mode is synthesizer and the target is transmit, a set-up count of D cycles runs on each clock where `pll_lock` is high. Transmit is entered on the clock after the count reaches D, which is D+1 clocks after the first clock with lock high. Any clock with lock low restarts the count.
- R7: With `ook_sel` low, D = `CYC_PER_US` × T. T is in microseconds and depends on `ramp_code`: 0→2000, 1→1000, 2→500, 3→250, 4→125, 5→100, 6→62, 7→50, 8→40, 9→31, 10→25, 11→20, 12→15, 13→12, 14→10, 15→8.
- R8: With `ook_sel` high, D = 5×`CYC_PER_US` + floor(`bit_cyc`/2).
- R9: When the target is lower than the current mode, the mode drops by one on every clock until it equals the target. No handshake is needed.
- R10: In transmit, a clock with `pll_lock` low returns the mode to synthesizer.
- R11: `tx_ready` is high exactly when the mode is transmit. `locked` is high when, after a clock, the mode is 010 or 011 and `pll_lock` was high at that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_mode | input | 3 | Requested operating mode |
| rc_on_req | input | 1 | Request to run the RC oscillator |
| xtal_rdy | input | 1 | Crystal oscillator has started |
| pll_lock | input | 1 | Synthesizer is locked |
| ook_sel | input | 1 | 1 selects on-off keying set-up delay |
| ramp_code | input | 4 | Amplifier ramp time selection |
| bit_cyc | input | BIT_W | Bit period in clock cycles |
| mode | output | 3 | Current operating mode |
| rc_en | output | 1 | RC oscillator enable |
| xo_en | output | 1 | Crystal oscillator enable |
| fs_en | output | 1 | Frequency synthesizer enable |
| pa_en | output | 1 | Power amplifier enable |
| locked | output | 1 | Lock indication while the synthesizer runs |
| tx_ready | output | 1 | Transmitter ready for data |

## Verification
The hardest condition to reach is a lock drop in the middle of a set-up count. The stimulus reaches it by first parking the block in synthesizer mode with transmit requested. It raises lock for part of the delay, drops it for a clock, then raises it again and measures the full delay from that second rise. A second hard case is the 2 ms ramp code, whose count runs to several thousand clocks. The bench reaches it by stepping down to synthesizer mode and re-requesting transmit, with the count measured from the request. A behavioural model that runs alongside compares every output on every clock. Directed checks also confirm the exact cycle counts for three ramp codes and for on-off keying.

// File: rtl/txmode_pkg.sv
package txmode_pkg;
  typedef enum logic [1:0] {
    MD_SLEEP = 2'd0,
    MD_STBY  = 2'd1,
    MD_SYNTH = 2'd2,
    MD_TX    = 2'd3
  } md_e;
endpackage

// File: rtl/txmode_req_filter.sv
// Registers the requested target mode; out-of-range codes keep the old target (R3).
module txmode_req_filter
  import txmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] req_code,
  output md_e        tgt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tgt <= MD_SLEEP;
    else if (!req_code[2])  tgt <= md_e'(req_code[1:0]);
  end
endmodule

// File: rtl/txmode_setup_timer.sv
// Counts the amplifier set-up delay while enabled (R6, R7, R8).
module txmode_setup_timer #(
  parameter int CYC_PER_US = 4,
  parameter int BIT_W      = 16,
  parameter int DLY_W      = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ook_sel,
  input  logic [3:0]       ramp_code,
  input  logic [BIT_W-1:0] bit_cyc,
  output logic             done
);
  localparam int OOK_BASE = 5 * CYC_PER_US;

  function automatic int ramp_us(input logic [3:0] c);
    case (c)
      4'd0:  ramp_us = 2000;
      4'd1:  ramp_us = 1000;
      4'd2:  ramp_us = 500;
      4'd3:  ramp_us = 250;
      4'd4:  ramp_us = 125;
      4'd5:  ramp_us = 100;
      4'd6:  ramp_us = 62;
      4'd7:  ramp_us = 50;
      4'd8:  ramp_us = 40;
      4'd9:  ramp_us = 31;
      4'd10: ramp_us = 25;
      4'd11: ramp_us = 20;
      4'd12: ramp_us = 15;
      4'd13: ramp_us = 12;
      4'd14: ramp_us = 10;
      default: ramp_us = 8;
    endcase
  endfunction

  logic [DLY_W-1:0] dly;
  logic [DLY_W-1:0] cnt;

  always_comb begin
    if (ook_sel) dly = DLY_W'(OOK_BASE + int'(bit_cyc >> 1));
    else         dly = DLY_W'(ramp_us(ramp_code) * CYC_PER_US);
  end

  assign done = run && (cnt == dly);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || done)   cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/txmode_en_map.sv
// Maps the current mode onto the stacked subsystem enables (R2).
module txmode_en_map
  import txmode_pkg::*;
(
  input  md_e  cur,
  output logic xo_en,
  output logic fs_en,
  output logic pa_en
);
  assign xo_en = (cur != MD_SLEEP);
  assign fs_en = (cur == MD_SYNTH) || (cur == MD_TX);
  assign pa_en = (cur == MD_TX);
endmodule

// File: rtl/txmode_seq.sv
module txmode_seq
  import txmode_pkg::*;
#(
  parameter int CYC_PER_US = 4,
  parameter int BIT_W      = 16,
  parameter int DLY_W      = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       req_mode,
  input  logic             rc_on_req,
  input  logic             xtal_rdy,
  input  logic             pll_lock,
  input  logic             ook_sel,
  input  logic [3:0]       ramp_code,
  input  logic [BIT_W-1:0] bit_cyc,
  output logic [2:0]       mode,
  output logic             rc_en,
  output logic             xo_en,
  output logic             fs_en,
  output logic             pa_en,
  output logic             locked,
  output logic             tx_ready
);
  md_e  tgt, cur, nxt;
  logic run, done;

  txmode_req_filter u_req (
    .clk(clk), .rst_n(rst_n), .req_code(req_mode), .tgt(tgt)
  );

  assign run = (cur == MD_SYNTH) && (tgt == MD_TX) && pll_lock;

  txmode_setup_timer #(
    .CYC_PER_US(CYC_PER_US), .BIT_W(BIT_W), .DLY_W(DLY_W)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(run), .ook_sel(ook_sel),
    .ramp_code(ramp_code), .bit_cyc(bit_cyc), .done(done)
  );

  always_comb begin
    nxt = cur;
    if (tgt < cur) begin
      nxt = md_e'(cur - 2'd1);               // R9 step down
    end else begin
      case (cur)
        MD_SLEEP: if (tgt != MD_SLEEP)          nxt = MD_STBY;   // R4
        MD_STBY:  if (tgt > MD_STBY && xtal_rdy) nxt = MD_SYNTH; // R5
        MD_SYNTH: if (done)                     nxt = MD_TX;     // R6
        default:  if (!pll_lock)                nxt = MD_SYNTH;  // R10
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= MD_SLEEP;
      rc_en  <= 1'b0;
      locked <= 1'b0;
    end else begin
      cur    <= nxt;
      rc_en  <= rc_on_req;
      locked <= pll_lock && ((nxt == MD_SYNTH) || (nxt == MD_TX));
    end
  end

  txmode_en_map u_en (
    .cur(cur), .xo_en(xo_en), .fs_en(fs_en), .pa_en(pa_en)
  );

  assign mode     = {1'b0, cur};
  assign tx_ready = (cur == MD_TX);
endmodule

// File: rtl/txmode_seq_chk.sv
module txmode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xtal_rdy,
  input logic       pll_lock,
  input logic [2:0] mode,
  input logic       xo_en,
  input logic       fs_en,
  input logic       pa_en,
  input logic       tx_ready
);
  a_r2_enable_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_en |-> fs_en) and (fs_en |-> xo_en));

  a_r5_synth_after_xtal: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_en && !$past(fs_en) && $past(mode) == 3'd1) |-> $past(xtal_rdy));

  a_r6_tx_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_en && !$past(pa_en)) |-> $past(pll_lock));

  a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> (mode == $past(mode) + 3'd1 || mode + 3'd1 == $past(mode)));

  a_r10_lock_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_en && !pll_lock) |=> (mode == 3'd2));

  a_r11_ready_is_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready == pa_en);
endmodule

bind txmode_seq txmode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xtal_rdy(xtal_rdy), .pll_lock(pll_lock),
  .mode(mode), .xo_en(xo_en), .fs_en(fs_en), .pa_en(pa_en), .tx_ready(tx_ready)
);

// File: tb/txmode_seq_tb_top.sv
`timescale 1ns/1ps
module txmode_seq_tb_top;
  localparam int CPU = 4;

  logic clk = 0, rst_n = 0;
  logic [2:0] req_mode = 0;
  logic rc_on_req = 0, xtal_rdy = 0, pll_lock = 0, ook_sel = 0;
  logic [3:0] ramp_code = 4'd15;
  logic [15:0] bit_cyc = 16'd0;
  logic [2:0] mode;
  logic rc_en, xo_en, fs_en, pa_en, locked, tx_ready;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  txmode_seq #(.CYC_PER_US(CPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_mode(req_mode), .rc_on_req(rc_on_req),
    .xtal_rdy(xtal_rdy), .pll_lock(pll_lock), .ook_sel(ook_sel),
    .ramp_code(ramp_code), .bit_cyc(bit_cyc), .mode(mode), .rc_en(rc_en),
    .xo_en(xo_en), .fs_en(fs_en), .pa_en(pa_en), .locked(locked),
    .tx_ready(tx_ready)
  );

  // Behavioural reference model
  int m_tgt = 0, m_cur = 0, m_cnt = 0;
  bit m_rc = 0, m_locked = 0;

  function automatic int ramp_time(input int c);
    int t[16] = '{2000, 1000, 500, 250, 125, 100, 62, 50, 40, 31, 25, 20, 15, 12, 10, 8};
    return t[c];
  endfunction

  function automatic int setup_cycles();
    if (ook_sel) return 5 * CPU + int'(bit_cyc) / 2;
    return ramp_time(int'(ramp_code)) * CPU;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      int nc;
      bit counting;
      nc = m_cur;
      counting = (m_cur == 2 && m_tgt == 3 && pll_lock);
      if (m_tgt < m_cur) nc = m_cur - 1;
      else if (m_cur == 0 && m_tgt > 0) nc = 1;
      else if (m_cur == 1 && m_tgt > 1 && xtal_rdy) nc = 2;
      else if (m_cur == 2 && counting && m_cnt == setup_cycles()) nc = 3;
      else if (m_cur == 3 && !pll_lock) nc = 2;
      if (counting && m_cnt != setup_cycles()) m_cnt++;
      else m_cnt = 0;
      if (req_mode < 4) m_tgt = int'(req_mode);
      m_cur = nc;
      m_rc = rc_on_req;
      m_locked = pll_lock && nc >= 2;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 mode", int'(mode), m_cur);
      check("R2 xo_en", int'(xo_en), int'(m_cur >= 1));
      check("R2 fs_en", int'(fs_en), int'(m_cur >= 2));
      check("R2 pa_en", int'(pa_en), int'(m_cur == 3));
      check("R1 rc_en", int'(rc_en), int'(m_rc));
      check("R11 tx_ready", int'(tx_ready), int'(m_cur == 3));
      check("R11 locked", int'(locked), int'(m_locked));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // counts negedges until tx_ready is seen
  task automatic measure(output int n);
    n = 0;
    while (n < 20000) begin
      @(negedge clk);
      n++;
      if (tx_ready) break;
    end
    #1;
  endtask

  task automatic summary();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    step(2);
    check("R1 reset mode", int'(mode), 0);
    check("R1 reset pa_en", int'(pa_en), 0);
    check("R1 reset tx_ready", int'(tx_ready), 0);
    rst_n = 1;
    step(1);
    // R3: invalid code from sleep
    req_mode = 3'b101; step(5);
    check("R3 invalid held sleep", int'(mode), 0);
    // R1: rc follows request
    rc_on_req = 1; step(2);
    check("R1 rc_en on", int'(rc_en), 1);
    // R4 / R5
    req_mode = 3'd3; step(2);
    check("R4 standby entered", int'(mode), 1);
    step(10);
    check("R5 waits for crystal", int'(mode), 1);
    xtal_rdy = 1; step(1);
    check("R5 synth after crystal", int'(mode), 2);
    // R7 code 15: D = 32
    pll_lock = 1; measure(n);
    check("R7 code15 delay", n, 8 * CPU + 1);
    // R3 in transmit
    req_mode = 3'b111; step(5);
    check("R3 invalid held tx", int'(mode), 3);
    // R10 lock loss
    pll_lock = 0; step(1);
    check("R10 back to synth", int'(mode), 2);
    check("R11 locked low", int'(locked), 0);
    // R6 restart of count, code 8: D = 160
    ramp_code = 4'd8; pll_lock = 1; step(50);
    check("R6 not yet tx", int'(mode), 2);
    pll_lock = 0; step(1);
    pll_lock = 1; measure(n);
    check("R6 R7 code8 restarted delay", n, 40 * CPU + 1);
    // R9 step down
    req_mode = 3'd0; step(2);
    check("R9 step to synth", int'(mode), 2);
    step(1);
    check("R9 step to standby", int'(mode), 1);
    step(1);
    check("R9 step to sleep", int'(mode), 0);
    // R8 OOK: D = 20 + 50
    ook_sel = 1; bit_cyc = 16'd101;
    req_mode = 3'd3;
    while (mode != 3'd2) step(1);
    measure(n);
    check("R8 ook delay", n, 5 * CPU + 50 + 1);
    // R7 code 0 via re-request from synth
    req_mode = 3'd2; step(3);
    check("R9 down to synth", int'(mode), 2);
    ook_sel = 0; ramp_code = 4'd0; req_mode = 3'd3;
    measure(n);
    check("R7 code0 delay", n, 2000 * CPU + 2);
    rc_on_req = 0; step(2);
    check("R1 rc_en off", int'(rc_en), 0);
    summary();
  end
endmodule